// File: doc/BRIEF.md
# Tiled Matrix Element Offset Generator

This block turns a two-dimensional element position (row, column) into a linear element offset for a matrix kept in memory as a grid of rectangular tiles. The tiles follow one another tile row by tile row, and the elements inside each tile are stored column after column. The matrix height and width and the nominal tile height and width are runtime inputs. When the tile size does not divide the matrix, the tiles in the last tile row are shorter and the tiles in the last tile column are narrower. The offsets count elements, not bytes.

There are two independent ways to use it. In lookup mode, a caller presents one position over a valid/ready handshake. Two iterative dividers split the position into a tile coordinate and an in-tile offset. The result is then held, with a valid flag, until the caller takes it. In sweep mode, one start pulse walks every element of the matrix at one per cycle. The sweep goes tile by tile and column by column inside each tile. It reports the position and the offset of each element and flags the final one. A tile's base is set once, when the sweep enters the tile; inside the tile the offset only steps forward, by one element down a column and by the tile height from one column start to the next.

A configuration with a zero dimension, or with a tile larger than the matrix, is reported on an error output. While it is present, neither mode produces output.

Top module: `tile4d_addr_gen`

## Requirements
- R1: After reset, rsp_valid and trv_valid are 0, and req_ready is 1 when the configuration is legal.
- R2: A lookup of (r, c) returns ti·n·tR + h·tC·tj + fj·h + fi. Here ti = r div tR, fi = r mod tR, tj = c div tC and fj = c mod tC. The value h is tR, except in the last tile row, where it is m − tR·(ceil(m/tR)−1).
- R3: rsp_valid rises exactly DW+1 clock edges after the edge that accepts a request. req_ready is 0 from the accepting edge until the response has been taken.
- R4: While rsp_valid is 1 and rsp_ready is 0, rsp_valid stays 1 and rsp_off does not change. The edge at which both are 1 clears rsp_valid, and req_ready is 1 again after that edge.
- R5: A sweep visits tiles in row-major tile order and, inside each tile, elements in column-major order. Every element of the m×n matrix is visited exactly once. trv_row and trv_col give the position of each element.
- R6: During a sweep, trv_valid is 1 on every cycle from the edge after the start pulse up to and including the final element. Each trv_off equals the R2 formula for (trv_row, trv_col), and is one more than the previous offset.
- R7: trv_last is 1 only on the final element, at position (m−1, n−1). trv_valid is 0 on the following cycle.
- R8: Edge tiles are handled for any matrix size and tile size within range, including tiles that do not divide the matrix and tiles that equal it. The last tile row uses the reduced height, and the last tile column uses the reduced width n − tC·(ceil(n/tC)−1).
- R9: cfg_err is 1 when m, n, tR or tC is zero, or when tR > m or tC > n. While cfg_err is 1, req_ready is 0 and a trv_start pulse starts no sweep.
- R10: trv_start is ignored while a sweep is running. Holding it high for the whole sweep changes neither the order nor the offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_rows | input | DW | Matrix height m |
| cfg_cols | input | DW | Matrix width n |
| cfg_trows | input | DW | Nominal tile height tR |
| cfg_tcols | input | DW | Nominal tile width tC |
| cfg_err | output | 1 | Illegal configuration |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request can be accepted |
| req_row | input | DW | Row of the lookup |
| req_col | input | DW | Column of the lookup |
| rsp_valid | output | 1 | Lookup result present |
| rsp_ready | input | 1 | Caller takes the result |
| rsp_off | output | 2*DW | Element offset of the lookup |
| trv_start | input | 1 | Start a sweep |
| trv_valid | output | 1 | Sweep element present |
| trv_last | output | 1 | Final element of the sweep |
| trv_row | output | DW | Row of the sweep element |
| trv_col | output | DW | Column of the sweep element |
| trv_off | output | 2*DW | Element offset of the sweep element |

## Verification
A lookup result is due DW+1 edges after the accepting edge. The bench therefore checks at every falling edge that rsp_valid is still low up to and including the DW-th edge, and then checks the value at the falling edge after edge DW+1. Sweep elements are due on every cycle starting at the edge after the start pulse. The bench builds the expected position sequence from its own tile loops, pops one entry per falling edge, and compares the position, offset and last flag. It then checks, one falling edge after the final element, that trv_valid has dropped. Error and ignore cases are checked at the ports on the cycle after the pulse that could have acted.

// File: rtl/tile4d_pkg.sv
package tile4d_pkg;
  typedef enum logic [1:0] {RA_IDLE, RA_DIV, RA_HOLD} ra_state_t;
endpackage

// File: rtl/tile4d_div.sv
module tile4d_div #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [DW-1:0] dividend,
  input  logic [DW-1:0] divisor,
  output logic [DW-1:0] quo,
  output logic [DW-1:0] rem,
  output logic          done
);
  localparam int CW = $clog2(DW) + 1;

  logic [DW-1:0] q_r, q_n, r_r, r_n, d_r, d_n;
  logic [CW-1:0] cnt_r, cnt_n;
  logic          busy_r, busy_n, done_r, done_n;
  logic [DW:0]   shifted, diff;
  logic          fits;

  always_comb begin
    shifted = {r_r, q_r[DW-1]};
    diff    = shifted - {1'b0, d_r};
    fits    = shifted >= {1'b0, d_r};
    q_n = q_r; r_n = r_r; d_n = d_r; cnt_n = cnt_r;
    busy_n = busy_r; done_n = done_r;
    if (start) begin
      q_n = dividend; r_n = '0; d_n = divisor; cnt_n = '0;
      busy_n = 1'b1; done_n = 1'b0;
    end else if (busy_r) begin
      q_n   = {q_r[DW-2:0], fits};
      r_n   = fits ? diff[DW-1:0] : shifted[DW-1:0];
      cnt_n = cnt_r + 1'b1;
      if (cnt_r == CW'(DW - 1)) begin
        busy_n = 1'b0;
        done_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0; r_r <= '0; d_r <= '0; cnt_r <= '0;
      busy_r <= 1'b0; done_r <= 1'b0;
    end else begin
      q_r <= q_n; r_r <= r_n; d_r <= d_n; cnt_r <= cnt_n;
      busy_r <= busy_n; done_r <= done_n;
    end
  end

  assign quo  = q_r;
  assign rem  = r_r;
  assign done = done_r;
endmodule

// File: rtl/tile4d_lookup.sv
module tile4d_lookup
  import tile4d_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [DW-1:0]   m,
  input  logic [DW-1:0]   n,
  input  logic [DW-1:0]   tr,
  input  logic [DW-1:0]   tc,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DW-1:0]   req_row,
  input  logic [DW-1:0]   req_col,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [2*DW-1:0] rsp_off
);
  localparam int OW = 2 * DW;

  ra_state_t     st_r, st_n;
  logic [OW-1:0] off_r, off_n;
  logic          accept;
  logic [DW-1:0] dvd [2];
  logic [DW-1:0] dvs [2];
  logic [DW-1:0] quo [2];
  logic [DW-1:0] rem [2];
  logic          dn  [2];

  assign dvd[0] = req_row;
  assign dvd[1] = req_col;
  assign dvs[0] = tr;
  assign dvs[1] = tc;

  for (genvar g = 0; g < 2; g++) begin : g_axis
    tile4d_div #(.DW(DW)) u_div (
      .clk(clk), .rst_n(rst_n), .start(accept),
      .dividend(dvd[g]), .divisor(dvs[g]),
      .quo(quo[g]), .rem(rem[g]), .done(dn[g])
    );
  end

  logic [OW-1:0] row0, left, h, base, inner;
  always_comb begin
    row0  = OW'(quo[0]) * OW'(tr);
    left  = OW'(m) - row0;
    h     = (left < OW'(tr)) ? left : OW'(tr);
    base  = row0 * OW'(n) + h * OW'(tc) * OW'(quo[1]);
    inner = OW'(rem[1]) * h + OW'(rem[0]);
  end

  assign req_ready = (st_r == RA_IDLE) && en;
  assign accept    = req_valid && req_ready;

  always_comb begin
    st_n  = st_r;
    off_n = off_r;
    case (st_r)
      RA_IDLE: if (accept) st_n = RA_DIV;
      RA_DIV:  if (dn[0]) begin
                 off_n = base + inner;
                 st_n  = RA_HOLD;
               end
      RA_HOLD: if (rsp_ready) st_n = RA_IDLE;
      default: st_n = RA_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_r  <= RA_IDLE;
      off_r <= '0;
    end else begin
      st_r  <= st_n;
      off_r <= off_n;
    end
  end

  assign rsp_valid = (st_r == RA_HOLD);
  assign rsp_off   = off_r;
endmodule

// File: rtl/tile4d_sweep.sv
module tile4d_sweep #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   m,
  input  logic [DW-1:0]   n,
  input  logic [DW-1:0]   tr,
  input  logic [DW-1:0]   tc,
  output logic            valid,
  output logic            last,
  output logic [DW-1:0]   row,
  output logic [DW-1:0]   col,
  output logic [2*DW-1:0] off
);
  localparam int OW = 2 * DW;

  logic          act_r, act_n;
  logic [DW-1:0] row0_r, row0_n, col0_r, col0_n;
  logic [DW-1:0] fi_r, fi_n, fj_r, fj_n, h_r, h_n, w_r, w_n;
  logic [OW-1:0] cb_r, cb_n;
  logic          h_end, w_end, r_end, c_end;
  logic [DW:0]   nr0, nc0, rleft, cleft;

  always_comb begin
    h_end = (fi_r == h_r - 1'b1);
    w_end = (fj_r == w_r - 1'b1);
    r_end = ({1'b0, row0_r} + {1'b0, h_r}) == {1'b0, m};
    c_end = ({1'b0, col0_r} + {1'b0, w_r}) == {1'b0, n};
    nr0   = {1'b0, row0_r} + {1'b0, tr};
    nc0   = {1'b0, col0_r} + {1'b0, tc};
    rleft = {1'b0, m} - nr0;
    cleft = {1'b0, n} - nc0;
    last  = act_r && h_end && w_end && r_end && c_end;
  end

  always_comb begin
    act_n = act_r; row0_n = row0_r; col0_n = col0_r;
    fi_n = fi_r; fj_n = fj_r; h_n = h_r; w_n = w_r; cb_n = cb_r;
    if (!act_r) begin
      if (start) begin
        act_n = 1'b1; row0_n = '0; col0_n = '0; fi_n = '0; fj_n = '0;
        h_n = tr; w_n = tc; cb_n = '0;
      end
    end else if (last) begin
      act_n = 1'b0;
    end else if (!h_end) begin
      fi_n = fi_r + 1'b1;
    end else begin
      fi_n = '0;
      cb_n = cb_r + OW'(h_r);
      if (!w_end) begin
        fj_n = fj_r + 1'b1;
      end else begin
        fj_n = '0;
        if (!c_end) begin
          col0_n = nc0[DW-1:0];
          w_n    = (cleft < {1'b0, tc}) ? cleft[DW-1:0] : tc;
        end else begin
          col0_n = '0;
          w_n    = tc;
          row0_n = nr0[DW-1:0];
          h_n    = (rleft < {1'b0, tr}) ? rleft[DW-1:0] : tr;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_r <= 1'b0; row0_r <= '0; col0_r <= '0; fi_r <= '0; fj_r <= '0;
      h_r <= '0; w_r <= '0; cb_r <= '0;
    end else begin
      act_r <= act_n; row0_r <= row0_n; col0_r <= col0_n; fi_r <= fi_n;
      fj_r <= fj_n; h_r <= h_n; w_r <= w_n; cb_r <= cb_n;
    end
  end

  assign valid = act_r;
  assign row   = row0_r + fi_r;
  assign col   = col0_r + fj_r;
  assign off   = cb_r + OW'(fi_r);
endmodule

// File: rtl/tile4d_addr_gen.sv
module tile4d_addr_gen #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DW-1:0]   cfg_rows,
  input  logic [DW-1:0]   cfg_cols,
  input  logic [DW-1:0]   cfg_trows,
  input  logic [DW-1:0]   cfg_tcols,
  output logic            cfg_err,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DW-1:0]   req_row,
  input  logic [DW-1:0]   req_col,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [2*DW-1:0] rsp_off,
  input  logic            trv_start,
  output logic            trv_valid,
  output logic            trv_last,
  output logic [DW-1:0]   trv_row,
  output logic [DW-1:0]   trv_col,
  output logic [2*DW-1:0] trv_off
);
  assign cfg_err = (cfg_rows == '0) || (cfg_cols == '0) ||
                   (cfg_trows == '0) || (cfg_tcols == '0) ||
                   (cfg_trows > cfg_rows) || (cfg_tcols > cfg_cols);

  tile4d_lookup #(.DW(DW)) u_lookup (
    .clk(clk), .rst_n(rst_n), .en(!cfg_err),
    .m(cfg_rows), .n(cfg_cols), .tr(cfg_trows), .tc(cfg_tcols),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_row(req_row), .req_col(req_col),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_off(rsp_off)
  );

  tile4d_sweep #(.DW(DW)) u_sweep (
    .clk(clk), .rst_n(rst_n), .start(trv_start && !cfg_err),
    .m(cfg_rows), .n(cfg_cols), .tr(cfg_trows), .tc(cfg_tcols),
    .valid(trv_valid), .last(trv_last),
    .row(trv_row), .col(trv_col), .off(trv_off)
  );
endmodule

// File: rtl/tile4d_chk.sv
module tile4d_chk #(
  parameter int DW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            cfg_err,
  input logic            req_ready,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [2*DW-1:0] rsp_off,
  input logic            trv_valid,
  input logic            trv_last,
  input logic [2*DW-1:0] trv_off
);
  localparam int OW = 2 * DW;

  // R3
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);

  // R4
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_off));

  // R6
  sweep_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trv_valid && !trv_last |=> trv_valid && (trv_off == $past(trv_off) + OW'(1)));

  // R7
  last_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trv_last |=> !trv_valid);

  // R9
  err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !req_ready);
endmodule

bind tile4d_addr_gen tile4d_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_err(cfg_err), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_off(rsp_off),
  .trv_valid(trv_valid), .trv_last(trv_last), .trv_off(trv_off)
);

// File: tb/sim_tile4d_addr_gen.sv
module sim_tile4d_addr_gen;
  localparam int DW = 8;
  localparam int OW = 2 * DW;

  logic clk = 1'b0;
  logic rst_n;
  logic [DW-1:0] cfg_rows, cfg_cols, cfg_trows, cfg_tcols;
  logic cfg_err, req_valid, req_ready, rsp_valid, rsp_ready;
  logic [DW-1:0] req_row, req_col, trv_row, trv_col;
  logic [OW-1:0] rsp_off, trv_off;
  logic trv_start, trv_valid, trv_last;

  int vectors = 0;
  int errors  = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  tile4d_addr_gen #(.DW(DW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int ref_off(int r, int c, int m, int n, int tr, int tc);
    int ti, fi, tj, fj, kr, h;
    ti = r / tr; fi = r % tr; tj = c / tc; fj = c % tc;
    kr = (m + tr - 1) / tr;
    h  = (ti == kr - 1) ? m - tr * (kr - 1) : tr;
    return ti * n * tr + h * tc * tj + fj * h + fi;
  endfunction

  task automatic set_cfg(input int m, input int n, input int tr, input int tc);
    @(negedge clk);
    cfg_rows = DW'(m); cfg_cols = DW'(n); cfg_trows = DW'(tr); cfg_tcols = DW'(tc);
  endtask

  // R2 R3 R4: one lookup with cycle-exact latency
  task automatic lookup(input int r, input int c, input int hold);
    int exp;
    exp = ref_off(r, c, cfg_rows, cfg_cols, cfg_trows, cfg_tcols);
    @(negedge clk);
    chk(req_ready == 1'b1, "R3 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_row = DW'(r); req_col = DW'(c); rsp_ready = 1'b0;
    @(posedge clk);
    for (int k = 0; k <= DW; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b0, "R3 early valid", rsp_valid, 0);
      chk(req_ready == 1'b0, "R3 ready while busy", req_ready, 0);
      @(posedge clk);
    end
    @(negedge clk);
    chk(rsp_valid == 1'b1, "R3 valid at DW+1", rsp_valid, 1);
    chk(int'(rsp_off) == exp, "R2 offset", rsp_off, exp);
    for (int k = 0; k < hold; k++) begin
      @(posedge clk); @(negedge clk);
      chk(rsp_valid == 1'b1 && int'(rsp_off) == exp, "R4 held", rsp_off, exp);
    end
    rsp_ready = 1'b1;
    @(posedge clk); @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, "R4 taken", rsp_valid, 0);
    chk(req_ready == 1'b1, "R4 ready again", req_ready, 1);
  endtask

  // R5 R6 R7 R8 R10: full sweep, start held high throughout
  task automatic sweep();
    int qr[$], qc[$];
    int m, n, tr, tc, kr, kc, h, w, idx, er, ec;
    m = cfg_rows; n = cfg_cols; tr = cfg_trows; tc = cfg_tcols;
    kr = (m + tr - 1) / tr; kc = (n + tc - 1) / tc;
    for (int ti = 0; ti < kr; ti++)
      for (int tj = 0; tj < kc; tj++) begin
        h = (ti == kr - 1) ? m - tr * (kr - 1) : tr;
        w = (tj == kc - 1) ? n - tc * (kc - 1) : tc;
        for (int fj = 0; fj < w; fj++)
          for (int fi = 0; fi < h; fi++) begin
            qr.push_back(ti * tr + fi); qc.push_back(tj * tc + fj);
          end
      end
    @(negedge clk);
    trv_start = 1'b1;
    @(posedge clk);
    idx = 0;
    while (qr.size() > 0) begin
      @(negedge clk);
      er = qr.pop_front(); ec = qc.pop_front();
      chk(trv_valid == 1'b1, "R6 valid each cycle", trv_valid, 1);
      chk(int'(trv_row) == er, "R5 row order", trv_row, er);
      chk(int'(trv_col) == ec, "R5 col order", trv_col, ec);
      chk(int'(trv_off) == ref_off(er, ec, m, n, tr, tc), "R8 sweep offset",
          trv_off, ref_off(er, ec, m, n, tr, tc));
      chk(int'(trv_off) == idx, "R6 consecutive", trv_off, idx);
      chk(trv_last == (qr.size() == 0), "R7 last flag", trv_last, qr.size() == 0);
      if (qr.size() == 0) trv_start = 1'b0;
      idx++;
      @(posedge clk);
    end
    @(negedge clk);
    chk(trv_valid == 1'b0, "R7 valid drops", trv_valid, 0);
    trv_start = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; rsp_ready = 1'b0; trv_start = 1'b0;
    req_row = '0; req_col = '0;
    cfg_rows = 8'd7; cfg_cols = 8'd10; cfg_trows = 8'd3; cfg_tcols = 8'd4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 rsp_valid reset", rsp_valid, 0);
    chk(trv_valid == 1'b0, "R1 trv_valid reset", trv_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(cfg_err == 1'b0, "R9 legal cfg", cfg_err, 0);

    // non-dividing tiles: every element by lookup
    for (int r = 0; r < 7; r++)
      for (int c = 0; c < 10; c++) lookup(r, c, (r + c) % 3);
    sweep();

    set_cfg(8, 8, 4, 2);
    lookup(5, 3, 1); lookup(7, 7, 0); lookup(0, 6, 2);
    sweep();

    set_cfg(5, 5, 5, 5);
    lookup(4, 4, 0); lookup(2, 3, 1);
    sweep();

    set_cfg(1, 9, 1, 3);
    lookup(0, 8, 0);
    sweep();

    set_cfg(13, 6, 4, 6);
    lookup(12, 5, 0); lookup(9, 2, 1);
    sweep();

    // R9 error configurations
    set_cfg(4, 6, 5, 2);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R9 tile too tall", cfg_err, 1);
    chk(req_ready == 1'b0, "R9 ready blocked", req_ready, 0);
    trv_start = 1'b1;
    @(posedge clk); @(negedge clk);
    trv_start = 1'b0;
    chk(trv_valid == 1'b0, "R9 sweep blocked", trv_valid, 0);
    set_cfg(0, 6, 1, 2);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R9 zero dim", cfg_err, 1);
    chk(req_ready == 1'b0, "R9 ready blocked zero", req_ready, 0);
    set_cfg(4, 6, 2, 7);
    @(negedge clk);
    chk(cfg_err == 1'b1, "R9 tile too wide", cfg_err, 1);
    set_cfg(4, 6, 2, 3);
    @(negedge clk);
    chk(cfg_err == 1'b0 && req_ready == 1'b1, "R9 recovered", req_ready, 1);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    finished = 1;
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule